// File: doc/BRIEF.md
# Transmit PLCP Frame Generator

This block builds the physical-layer convergence frames that carry 53-byte ATM cells over a DS3 payload. It takes cells from an upstream source through a valid/ready handshake. It wraps each cell in a row: two fixed alignment bytes, a row identifier byte and one path-overhead byte, followed by the cell. Twelve rows make a frame, and a trailer of 13 or 14 nibbles closes it. The result leaves as a byte stream toward a DS3 framer, one byte for each cycle the framer grants with `byte_en`. A strobe marks the first byte of every frame.

The trailer length is the stuffing decision. Frames run in a three-frame phase cycle. The first phase always uses 13 nibbles and the second always uses 14. The third phase is decided by a selectable source: a fixed alternating pattern, an external control pin, or a phase balance against an 8 kHz reference tick or a receive-side frame tick. The overhead carries an even BIP-8 over the previous frame, a far-end error count with a remote alarm bit, and a code for the current stuffing phase. A direct-mapping mode drops all framing, so cells fill every output byte back to back.

Top module: `plcp_tx_framer`

## Requirements
- R1: A frame is 12 rows. Each row is 0xF6, then 0x28, then an identifier byte, then one overhead byte, then 53 cell bytes. `out_sof` is high only with the 0xF6 byte of row 0.
- R2: The identifier byte of row r (r = 0..11) uses n = 11 − r and equals {n[3:0], ~n[3:0]}.
- R3: The overhead byte is 0x00 in rows 0–6, 9 and 10. Row 7 carries the BIP byte. Row 8 carries {febe[3:0], rai, 3'b000}. Row 11 carries the phase code.
- R4: The BIP byte is the XOR of all overhead and cell bytes of every row of the previous frame. It is 0x00 in the first frame after reset.
- R5: Seven trailer beats follow row 11. For 14 nibbles they are seven 0xCC bytes with `out_half` low. For 13 nibbles they are six 0xCC bytes, then 0xC0 with `out_half` high, which means only the upper nibble is valid.
- R6: Frames run phases 0, 1, 2, 0, … starting at phase 0 after reset. Phase 0 uses 13 nibbles and phase code 0xFF. Phase 1 uses 14 nibbles and code 0x00. Phase 2 is decided by the source and uses code 0x99 for 14 nibbles or 0x66 for 13.
- R7: `stuff_sel` = 0 selects the fixed pattern: phase-2 frames alternate, 13 nibbles first, then 14. `stuff_sel` = 1 selects the pin: `stuff_pin` is sampled on the frame's first beat, and 1 means 14 nibbles.
- R8: `stuff_sel` = 2 selects `ref_tick` and `stuff_sel` = 3 selects `rx_tick`. A balance counter saturating at ±7 adds 1 per selected tick and subtracts 1 per frame start. A phase-2 frame uses 13 nibbles if the balance is above zero at its first beat, otherwise 14. The tick that is not selected has no effect.
- R9: At the first cell byte of a row, if `cell_valid` is high the cell is taken: `cell_ready` is high on its 53 enabled beats and `cell_data` is forwarded. Otherwise an idle cell 00 00 00 01 52 followed by 48 bytes of 0x6A is sent, and `cell_ready` stays low.
- R10: Each cycle with `byte_en` high emits exactly one byte, and `out_vld` is high in the following cycle. Nothing advances while `byte_en` is low.
- R11: `direct_map` is sampled at a frame boundary, or at a cell boundary while in direct mode. When it is set, output is back-to-back cells with no framing bytes and no `out_sof`.
- R12: During reset `out_vld`, `out_sof` and `out_half` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_en | input | 1 | Downstream grants one output byte this cycle |
| direct_map | input | 1 | Bypass framing, cells only |
| stuff_sel | input | 2 | Stuffing source: 0 fixed, 1 pin, 2 reference tick, 3 receive tick |
| stuff_pin | input | 1 | External stuff request |
| ref_tick | input | 1 | 8 kHz reference pulse |
| rx_tick | input | 1 | Receive-side frame pulse |
| febe | input | 4 | Far-end block error count for the overhead |
| rai | input | 1 | Remote alarm bit for the overhead |
| cell_valid | input | 1 | Upstream cell byte valid |
| cell_data | input | 8 | Upstream cell byte |
| cell_ready | output | 1 | Cell byte accepted this cycle |
| out_vld | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of a frame |
| out_half | output | 1 | Only the upper nibble of `out_data` is valid |

## Verification
The frame builder is driven with the cell supply running out partway through a frame, so real cells and idle cells can be told apart by position. It is also driven with gaps in `byte_en`, which separates beat counting from clock counting. Each stuffing source is run in its own setup: six frames of the fixed pattern show both phase-2 outcomes. The pin, the reference-tick surplus and the receive-tick deficit each force a known phase-2 result. The receive-tick run keeps reference ticks flowing to show that the unselected source is ignored. A direct-mapping run, with fewer cells than slots, shows that cells and idle cells follow each other with no framing. The BIP byte of each frame is checked against the bench's own XOR of the frame before it.

// File: rtl/plcp_tx_pkg.sv
package plcp_tx_pkg;

  typedef enum logic [2:0] {
    SL_A1   = 3'd0,
    SL_A2   = 3'd1,
    SL_POI  = 3'd2,
    SL_POH  = 3'd3,
    SL_CELL = 3'd4,
    SL_TRL  = 3'd5
  } slot_e;

  typedef enum logic [1:0] {
    SRC_FIXED  = 2'd0,
    SRC_PIN    = 2'd1,
    SRC_REF8K  = 2'd2,
    SRC_RXPLCP = 2'd3
  } stuff_src_e;

  localparam logic [7:0] ALIGN1_BYTE  = 8'hF6;
  localparam logic [7:0] ALIGN2_BYTE  = 8'h28;
  localparam logic [7:0] TRL_FULL     = 8'hCC;
  localparam logic [7:0] TRL_HALF     = 8'hC0;
  localparam logic [7:0] PH0_CODE     = 8'hFF;
  localparam logic [7:0] PH1_CODE     = 8'h00;
  localparam logic [7:0] PH2_STF_CODE = 8'h99;
  localparam logic [7:0] PH2_NOS_CODE = 8'h66;

  function automatic logic [7:0] poi_code(input logic [3:0] n);
    return {n, ~n};
  endfunction

  function automatic logic [7:0] idle_byte(input logic [5:0] idx);
    logic [7:0] b;
    if (idx < 6'd3)       b = 8'h00;
    else if (idx == 6'd3) b = 8'h01;
    else if (idx == 6'd4) b = 8'h52;
    else                  b = 8'h6A;
    return b;
  endfunction

endpackage

// File: rtl/plcp_tx_seq.sv
module plcp_tx_seq
  import plcp_tx_pkg::*;
#(
  parameter int NROWS      = 12,
  parameter int CELL_BYTES = 53,
  parameter int TRL_BEATS  = 7,
  localparam int HDR       = 4,
  localparam int ROW_LEN   = HDR + CELL_BYTES,
  localparam int COL_W     = $clog2(ROW_LEN),
  localparam int ROW_W     = $clog2(NROWS),
  localparam int TRL_W     = $clog2(TRL_BEATS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_en,
  input  logic             direct_map,
  output slot_e            kind,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] cidx,
  output logic [TRL_W-1:0] tidx,
  output logic             direct_now,
  output logic             frame_top,
  output logic             cell_first,
  output logic             trl_last
);

  localparam logic [COL_W-1:0] COL_LAST = COL_W'(ROW_LEN - 1);
  localparam logic [COL_W-1:0] COL_HDR  = COL_W'(HDR);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NROWS - 1);
  localparam logic [TRL_W-1:0] TRL_LAST = TRL_W'(TRL_BEATS - 1);

  logic [COL_W-1:0] col_q, col_n;
  logic [ROW_W-1:0] row_q, row_n;
  logic [TRL_W-1:0] tcnt_q, tcnt_n;
  logic             trl_q, trl_n;
  logic             mode_q, mode_n;
  logic             at_top;

  assign at_top     = !mode_q && !trl_q && (col_q == '0) && (row_q == '0);
  assign direct_now = at_top ? direct_map : mode_q;
  assign frame_top  = at_top && !direct_map;
  assign row        = row_q;
  assign tidx       = tcnt_q;
  assign trl_last   = trl_q && (tcnt_q == TRL_LAST);

  // slot decode
  always_comb begin
    kind = SL_CELL;
    cidx = col_q - COL_HDR;
    if (direct_now) begin
      kind = SL_CELL;
      cidx = at_top ? '0 : (col_q - COL_HDR);
    end else if (trl_q) begin
      kind = SL_TRL;
    end else begin
      case (col_q)
        COL_W'(0): kind = SL_A1;
        COL_W'(1): kind = SL_A2;
        COL_W'(2): kind = SL_POI;
        COL_W'(3): kind = SL_POH;
        default:   kind = SL_CELL;
      endcase
    end
  end

  assign cell_first = (kind == SL_CELL) && (cidx == '0);

  // next position
  always_comb begin
    col_n  = col_q;
    row_n  = row_q;
    tcnt_n = tcnt_q;
    trl_n  = trl_q;
    mode_n = mode_q;
    if (direct_now) begin
      if (at_top) begin
        mode_n = 1'b1;
        col_n  = COL_HDR + COL_W'(1);
      end else if (col_q == COL_LAST) begin
        if (direct_map) begin
          col_n = COL_HDR;
        end else begin
          col_n  = '0;
          row_n  = '0;
          mode_n = 1'b0;
        end
      end else begin
        col_n = col_q + COL_W'(1);
      end
    end else if (trl_q) begin
      if (tcnt_q == TRL_LAST) begin
        trl_n  = 1'b0;
        tcnt_n = '0;
        col_n  = '0;
        row_n  = '0;
      end else begin
        tcnt_n = tcnt_q + TRL_W'(1);
      end
    end else if (col_q == COL_LAST) begin
      col_n = '0;
      if (row_q == ROW_LAST) begin
        trl_n = 1'b1;
        row_n = '0;
      end else begin
        row_n = row_q + ROW_W'(1);
      end
    end else begin
      col_n = col_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= '0;
      tcnt_q <= '0;
      trl_q  <= 1'b0;
      mode_q <= 1'b0;
    end else if (byte_en) begin
      col_q  <= col_n;
      row_q  <= row_n;
      tcnt_q <= tcnt_n;
      trl_q  <= trl_n;
      mode_q <= mode_n;
    end
  end

  // R10: position frozen while no byte is granted
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_en |=> $stable(col_q) && $stable(row_q) && $stable(trl_q) && $stable(mode_q));

  // R1: row counter stays inside the frame
  assert_row_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    row_q <= ROW_LAST);

endmodule

// File: rtl/plcp_tx_stuff.sv
module plcp_tx_stuff
  import plcp_tx_pkg::*;
#(
  parameter int BAL_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_adv,
  input  logic [1:0] sel,
  input  logic       stuff_pin,
  input  logic       ref_tick,
  input  logic       rx_tick,
  output logic       stuff_q,
  output logic [7:0] c1_code
);

  localparam logic signed [BAL_W-1:0] BAL_MAX = {1'b0, {(BAL_W-1){1'b1}}};
  localparam logic signed [BAL_W-1:0] BAL_MIN = -BAL_MAX;
  localparam logic signed [BAL_W-1:0] BAL_ONE = 1;

  stuff_src_e              src;
  logic [1:0]              phase_q, phase_n;
  logic                    alt_q, alt_n;
  logic                    stuff_n;
  logic signed [BAL_W-1:0] bal_q, bal_n;
  logic                    tick, bal_pos, p2_dec;

  assign src     = stuff_src_e'(sel);
  assign bal_pos = (bal_q != '0) && !bal_q[BAL_W-1];

  always_comb begin
    case (src)
      SRC_REF8K:  tick = ref_tick;
      SRC_RXPLCP: tick = rx_tick;
      default:    tick = 1'b0;
    endcase
    case (src)
      SRC_FIXED: p2_dec = alt_q;
      SRC_PIN:   p2_dec = stuff_pin;
      default:   p2_dec = !bal_pos;
    endcase
  end

  always_comb begin
    phase_n = (phase_q == 2'd2) ? 2'd0 : phase_q + 2'd1;
    case (phase_n)
      2'd0:    stuff_n = 1'b0;
      2'd1:    stuff_n = 1'b1;
      default: stuff_n = p2_dec;
    endcase
    alt_n = alt_q;
    if (phase_n == 2'd2 && src == SRC_FIXED) alt_n = ~alt_q;
  end

  always_comb begin
    bal_n = bal_q;
    if (!sel[1])                                       bal_n = '0;
    else if (tick && !frame_adv && bal_q != BAL_MAX)  bal_n = bal_q + BAL_ONE;
    else if (!tick && frame_adv && bal_q != BAL_MIN)  bal_n = bal_q - BAL_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 2'd2;
      stuff_q <= 1'b0;
      alt_q   <= 1'b0;
    end else if (frame_adv) begin
      phase_q <= phase_n;
      stuff_q <= stuff_n;
      alt_q   <= alt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bal_q <= '0;
    else        bal_q <= bal_n;
  end

  always_comb begin
    case (phase_q)
      2'd0:    c1_code = PH0_CODE;
      2'd1:    c1_code = PH1_CODE;
      default: c1_code = stuff_q ? PH2_STF_CODE : PH2_NOS_CODE;
    endcase
  end

  // R6: the frame after a phase-0 frame is phase 1 with 14 nibbles
  assert_phase1_stuff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_adv && phase_q == 2'd0 |=> stuff_q && phase_q == 2'd1);

  // R6: a new phase-0 frame never stuffs
  assert_phase0_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_adv && phase_q == 2'd2 |=> !stuff_q && phase_q == 2'd0);

  // R8: balance stays within its symmetric range
  assert_bal_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bal_q != {1'b1, {(BAL_W-1){1'b0}}});

endmodule

// File: rtl/plcp_tx_bip.sv
module plcp_tx_bip (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_en,
  input  logic [7:0] data,
  input  logic       frame_end,
  output logic [7:0] b1
);

  logic [7:0] acc_q, acc_n;
  logic [7:0] b1_q, b1_n;

  always_comb begin
    acc_n = acc_q;
    b1_n  = b1_q;
    if (frame_end) begin
      b1_n  = acc_q;
      acc_n = '0;
    end else if (acc_en) begin
      acc_n = acc_q ^ data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      b1_q  <= '0;
    end else begin
      acc_q <= acc_n;
      b1_q  <= b1_n;
    end
  end

  assign b1 = b1_q;

  // R4: parity byte only moves at a frame end
  assert_b1_frame_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(b1_q));

endmodule

// File: rtl/plcp_tx_framer.sv
module plcp_tx_framer
  import plcp_tx_pkg::*;
#(
  parameter int NROWS      = 12,
  parameter int CELL_BYTES = 53
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_en,
  input  logic       direct_map,
  input  logic [1:0] stuff_sel,
  input  logic       stuff_pin,
  input  logic       ref_tick,
  input  logic       rx_tick,
  input  logic [3:0] febe,
  input  logic       rai,
  input  logic       cell_valid,
  input  logic [7:0] cell_data,
  output logic       cell_ready,
  output logic       out_vld,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_half
);

  localparam int TRL_NIB_MAX = 14;
  localparam int TRL_BEATS   = TRL_NIB_MAX / 2;
  localparam int ROW_LEN     = 4 + CELL_BYTES;
  localparam int COL_W       = $clog2(ROW_LEN);
  localparam int ROW_W       = $clog2(NROWS);
  localparam int TRL_W       = $clog2(TRL_BEATS);
  localparam logic [ROW_W-1:0] ROW_B1 = ROW_W'(NROWS - 5);
  localparam logic [ROW_W-1:0] ROW_G1 = ROW_W'(NROWS - 4);
  localparam logic [ROW_W-1:0] ROW_C1 = ROW_W'(NROWS - 1);
  localparam logic [ROW_W-1:0] ROW_TOP = ROW_W'(NROWS - 1);

  slot_e            kind;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] cidx;
  logic [TRL_W-1:0] tidx;
  logic             direct_now, frame_top, cell_first, trl_last;
  logic             stuff_q;
  logic [7:0]       c1_code, b1;
  logic             live_q, live;
  logic [7:0]       data_n, poh_byte;
  logic             half_n;
  logic             frame_adv, frame_end, acc_en;

  plcp_tx_seq #(
    .NROWS(NROWS), .CELL_BYTES(CELL_BYTES), .TRL_BEATS(TRL_BEATS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .direct_map(direct_map),
    .kind(kind), .row(row), .cidx(cidx), .tidx(tidx),
    .direct_now(direct_now), .frame_top(frame_top),
    .cell_first(cell_first), .trl_last(trl_last)
  );

  assign frame_adv = byte_en && frame_top;
  assign frame_end = byte_en && trl_last;
  assign acc_en    = byte_en && !direct_now && (kind == SL_POH || kind == SL_CELL);

  plcp_tx_stuff #(.BAL_W(4)) u_stuff (
    .clk(clk), .rst_n(rst_n), .frame_adv(frame_adv), .sel(stuff_sel),
    .stuff_pin(stuff_pin), .ref_tick(ref_tick), .rx_tick(rx_tick),
    .stuff_q(stuff_q), .c1_code(c1_code)
  );

  plcp_tx_bip u_bip (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .data(data_n),
    .frame_end(frame_end), .b1(b1)
  );

  // cell intake: decided at the first byte, held for the rest of the cell
  assign live       = cell_first ? cell_valid : live_q;
  assign cell_ready = byte_en && (kind == SL_CELL) && live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     live_q <= 1'b0;
    else if (byte_en && cell_first) live_q <= cell_valid;
  end

  always_comb begin
    if (row == ROW_B1)      poh_byte = b1;
    else if (row == ROW_G1) poh_byte = {febe, rai, 3'b000};
    else if (row == ROW_C1) poh_byte = c1_code;
    else                    poh_byte = 8'h00;
  end

  always_comb begin
    half_n = 1'b0;
    case (kind)
      SL_A1:   data_n = ALIGN1_BYTE;
      SL_A2:   data_n = ALIGN2_BYTE;
      SL_POI:  data_n = poi_code(4'(ROW_TOP - row));
      SL_POH:  data_n = poh_byte;
      SL_TRL: begin
        half_n = trl_last && !stuff_q;
        data_n = half_n ? TRL_HALF : TRL_FULL;
      end
      default: data_n = live ? cell_data : idle_byte(6'(cidx));
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_sof  <= 1'b0;
      out_half <= 1'b0;
    end else begin
      out_vld  <= byte_en;
      out_sof  <= frame_adv;
      out_half <= byte_en && half_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_data <= '0;
    else if (byte_en) out_data <= data_n;
  end

  // R1: frame strobe sits on a valid first alignment byte
  assert_sof_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_vld && out_data == ALIGN1_BYTE);

  // R5: a half beat carries a single trailer nibble
  assert_half_nibble_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_half |-> out_vld && out_data == TRL_HALF);

endmodule

// File: tb/tb_plcp_tx_framer.sv
module tb_plcp_tx_framer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_en = 1'b0;
  logic       direct_map = 1'b0;
  logic [1:0] stuff_sel = 2'd0;
  logic       stuff_pin = 1'b0;
  logic       ref_tick = 1'b0;
  logic       rx_tick = 1'b0;
  logic [3:0] febe = 4'h0;
  logic       rai = 1'b0;
  logic       cell_valid = 1'b0;
  logic [7:0] cell_data = 8'h00;
  logic       cell_ready, out_vld, out_sof, out_half;
  logic [7:0] out_data;

  plcp_tx_framer dut (
    .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .direct_map(direct_map),
    .stuff_sel(stuff_sel), .stuff_pin(stuff_pin), .ref_tick(ref_tick),
    .rx_tick(rx_tick), .febe(febe), .rai(rai), .cell_valid(cell_valid),
    .cell_data(cell_data), .cell_ready(cell_ready), .out_vld(out_vld),
    .out_data(out_data), .out_sof(out_sof), .out_half(out_half)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0, errors = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];

  // bench model state
  int cells_total = 0, m_cell = 0, phase_m = 2;
  bit alt_m = 0;
  logic [7:0] bip_m = 8'h00, acc_m = 8'h00;
  int f_cell = 0, f_byte = 0;
  bit ref_on = 0;
  int gap_on = 0;

  function automatic logic [7:0] cbyte(input int k, input int j);
    return 8'((k * 7 + j * 3 + 1));
  endfunction

  function automatic logic [7:0] idle_exp(input int j);
    if (j < 3) return 8'h00;
    if (j == 3) return 8'h01;
    if (j == 4) return 8'h52;
    return 8'h6A;
  endfunction

  task automatic push(input logic [7:0] d, input bit sof, input bit half, input string tag);
    exp_q.push_back({sof, half, d});
    tag_q.push_back(tag);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one cell slot: real cell while supply lasts, idle cell after (R9)
  task automatic push_cell(input string tag);
    for (int j = 0; j < 53; j++) begin
      logic [7:0] b;
      b = (m_cell < cells_total) ? cbyte(m_cell, j) : idle_exp(j);
      acc_m ^= b;
      push(b, 0, 0, tag);
    end
    if (m_cell < cells_total) m_cell++;
  endtask

  // R1 R2 R3 R4 R5 R6 expected frame
  task automatic push_frame(input bit fixed_src, input bit p2);
    bit stf;
    logic [7:0] c1, poh;
    phase_m = (phase_m == 2) ? 0 : phase_m + 1;
    if (phase_m == 0) stf = 0;
    else if (phase_m == 1) stf = 1;
    else if (fixed_src) begin stf = alt_m; alt_m = !alt_m; end
    else stf = p2;
    c1 = (phase_m == 0) ? 8'hFF : (phase_m == 1) ? 8'h00 : (stf ? 8'h99 : 8'h66);
    acc_m = 8'h00;
    for (int r = 0; r < 12; r++) begin
      logic [3:0] n;
      n = 4'(11 - r);
      push(8'hF6, r == 0, 0, "R1");
      push(8'h28, 0, 0, "R1");
      push({n, ~n}, 0, 0, "R2");
      if (r == 7) poh = bip_m;
      else if (r == 8) poh = {febe, rai, 3'b000};
      else if (r == 11) poh = c1;
      else poh = 8'h00;
      acc_m ^= poh;
      push(poh, 0, 0, (r == 7) ? "R4" : (r == 11) ? "R6" : "R3");
      push_cell("R9");
    end
    for (int t = 0; t < 6; t++) push(8'hCC, 0, 0, "R5");
    if (stf) push(8'hCC, 0, 0, "R5");
    else     push(8'hC0, 0, 1, "R5");
    bip_m = acc_m;
  endtask

  // monitor: scoreboard compare
  initial begin
    forever begin
      @(negedge clk);
      if (out_vld) begin
        if (exp_q.size() == 0) begin
          check(0, "R10 extra byte", int'(out_data), 0);
        end else begin
          logic [9:0] e;
          logic [9:0] a;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          a = {out_sof, out_half, out_data};
          check(a == e, t, int'(a), int'(e));
        end
      end
    end
  end

  // upstream cell source
  initial begin
    forever begin
      bit take;
      @(negedge clk);
      take = cell_valid && cell_ready;
      @(posedge clk);
      #1;
      if (take) begin
        f_byte++;
        if (f_byte == 53) begin f_byte = 0; f_cell++; end
      end
      cell_valid = (f_cell < cells_total);
      cell_data  = cbyte(f_cell, f_byte);
    end
  end

  // reference tick generator
  initial begin
    int n = 0;
    forever begin
      @(posedge clk);
      #1;
      n++;
      ref_tick = ref_on && (n % 20 == 0);
    end
  end

  task automatic run_beats(input int n);
    int done = 0, cyc = 0;
    while (done < n) begin
      @(posedge clk);
      #1;
      byte_en = !(gap_on != 0 && (cyc % 3 == 2));
      if (byte_en) done++;
      cyc++;
    end
    @(posedge clk);
    #1;
    byte_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R10 missing bytes", exp_q.size(), 0);
    check(!out_vld, "R10 vld after stop", int'(out_vld), 0);
  endtask

  task automatic start(input int sel, input bit pin, input bit dmap, input int ncells,
                       input bit ron, input int gap);
    @(posedge clk);
    #1;
    rst_n = 0;
    byte_en = 0;
    stuff_sel = 2'(sel);
    stuff_pin = pin;
    direct_map = dmap;
    cells_total = ncells;
    f_cell = 0;
    f_byte = 0;
    ref_on = ron;
    gap_on = gap;
    m_cell = 0;
    phase_m = 2;
    alt_m = 0;
    bip_m = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    check(!out_vld && !out_sof && !out_half, "R12 reset outputs",
          int'({out_vld, out_sof, out_half}), 0);
    @(posedge clk);
    #1;
    rst_n = 1;
  endtask

  initial begin
    // fixed pattern, supply runs dry in frame 1 (R6 R7 R9 R4)
    febe = 4'h3; rai = 0;
    start(0, 0, 0, 20, 0, 0);
    for (int f = 0; f < 6; f++) push_frame(1, 0);
    run_beats(6 * 691);

    // pin source, gapped byte grants (R7 R10 R3)
    febe = 4'hA; rai = 1;
    start(1, 1, 0, 30, 0, 1);
    for (int f = 0; f < 3; f++) push_frame(0, 1);
    run_beats(3 * 691);

    // reference surplus gives 13 nibbles on phase 2 (R8)
    febe = 4'h0; rai = 0;
    start(2, 1, 0, 5, 1, 0);
    for (int f = 0; f < 3; f++) push_frame(0, 0);
    run_beats(3 * 691);

    // receive source with no ticks; reference ticks ignored (R8)
    start(3, 0, 0, 5, 1, 0);
    for (int f = 0; f < 3; f++) push_frame(0, 1);
    run_beats(3 * 691);

    // direct mapping: cells back to back, then idle cells (R11)
    start(0, 0, 1, 3, 0, 0);
    acc_m = 8'h00;
    for (int c = 0; c < 5; c++) push_cell("R11");
    run_beats(5 * 53);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule